// File: doc/BRIEF.md
# Emulated Internal Tri-State Bus Resolver

This block stands in for a shared tri-state bus inside a chip. A real bus of that kind floats when nobody drives it and carries a conflict when several drivers are on. Here each of `N_SRC` sources presents a data word and an output-enable. A combinational AND-OR multiplexer reduces them to one defined bus value, and no high-impedance driver is involved.

If exactly one enable is active, the bus carries that source's word. If two or more enables are active, the bus is forced to all zeros. If no enable is active, the bus is forced to all ones. Two status flags report the conflict case and the undriven case for debug. The block has no clock and no state, so every output follows its inputs in the same time step.

Top module: `tsbus_resolver`

## Requirements
- R1: With exactly one bit of `src_oe` high, `bus_out` equals that source's data word.
- R2: With two or more bits of `src_oe` high, `bus_out` is all zeros whatever the data.
- R3: With `src_oe` all zero, `bus_out` is all ones whatever the data.
- R4: `bus_conflict` is 1 exactly when two or more bits of `src_oe` are high.
- R5: `bus_idle` is 1 exactly when no bit of `src_oe` is high, and `bus_conflict` and `bus_idle` are never both high.
- R6: The data of a disabled source has no effect on any output.
- R7: Source i owns bit i of `src_oe` and bits [i*WIDTH +: WIDTH] of `src_data`, with source 0 in the least significant position.
- R8: The outputs carry no X or Z for any input combination and are purely combinational, settling in the same time step as the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| src_data | input | N_SRC*WIDTH | Packed data words, source i at bits [i*WIDTH +: WIDTH] |
| src_oe | input | N_SRC | Output-enable per source, bit i for source i |
| bus_out | output | WIDTH | Resolved bus value |
| bus_conflict | output | 1 | Two or more sources enabled |
| bus_idle | output | 1 | No source enabled |

## Verification
Every result of this block is due in zero cycles. `bus_out` and both flags are a pure function of the current `src_oe` and `src_data`. The bench therefore applies each stimulus on a rising clock edge and samples on the following falling edge, half a period later. By that point the combinational outputs have settled, and no earlier vector can still be in flight. The checks relate each sample only to the inputs applied on that same edge.

// File: rtl/tsbus_resolver.sv
module tsbus_resolver #(
  parameter int N_SRC = 4,
  parameter int WIDTH = 8
) (
  input  logic [N_SRC*WIDTH-1:0] src_data,
  input  logic [N_SRC-1:0]       src_oe,
  output logic [WIDTH-1:0]       bus_out,
  output logic                   bus_conflict,
  output logic                   bus_idle
);

  logic [WIDTH-1:0] and_or [N_SRC+1];
  logic [N_SRC:0]   seen;
  logic [N_SRC:0]   multi;

  assign and_or[0] = '0;
  assign seen[0]   = 1'b0;
  assign multi[0]  = 1'b0;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign and_or[i+1] = and_or[i] | (src_data[i*WIDTH +: WIDTH] & {WIDTH{src_oe[i]}});
    assign seen[i+1]   = seen[i] | src_oe[i];
    assign multi[i+1]  = multi[i] | (seen[i] & src_oe[i]);
  end

  assign bus_idle     = ~seen[N_SRC];
  assign bus_conflict = multi[N_SRC];
  assign bus_out      = bus_idle     ? {WIDTH{1'b1}} :
                        bus_conflict ? {WIDTH{1'b0}} : and_or[N_SRC];

endmodule

module tsbus_resolver_chk #(
  parameter int N_SRC = 4,
  parameter int WIDTH = 8
) (
  input logic [N_SRC*WIDTH-1:0] src_data,
  input logic [N_SRC-1:0]       src_oe,
  input logic [WIDTH-1:0]       bus_out,
  input logic                   bus_conflict,
  input logic                   bus_idle
);

  always_comb begin
    // R8
    known_out_chk: assert (!$isunknown({bus_out, bus_conflict, bus_idle}));
    // R5
    flags_excl_chk: assert (!(bus_conflict && bus_idle));
    // R4
    conflict_flag_chk: assert (bus_conflict == ($countones(src_oe) > 1));
    // R5
    idle_flag_chk: assert (bus_idle == (src_oe == '0));
    // R2
    if ($countones(src_oe) > 1) conflict_zero_chk: assert (bus_out == '0);
    // R3
    if (src_oe == '0) idle_ones_chk: assert (bus_out == '1);
    for (int i = 0; i < N_SRC; i++) begin
      // R1
      if ($onehot(src_oe) && src_oe[i])
        single_src_chk: assert (bus_out == src_data[i*WIDTH +: WIDTH]);
    end
  end

endmodule

bind tsbus_resolver tsbus_resolver_chk #(.N_SRC(N_SRC), .WIDTH(WIDTH)) u_chk (
  .src_data(src_data), .src_oe(src_oe), .bus_out(bus_out),
  .bus_conflict(bus_conflict), .bus_idle(bus_idle)
);

// File: tb/sim_tsbus_resolver.sv
module sim_tsbus_resolver;
  localparam int N = 4;
  localparam int W = 8;
  localparam int VW = N + N*W + W + 2;
  localparam int NV = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N*W-1:0] src_data = '0;
  logic [N-1:0]   src_oe = '0;
  logic [W-1:0]   bus_out;
  logic           bus_conflict, bus_idle;
  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  // fields: oe, data, expected bus, expected conflict, expected idle
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'b0001, 32'hA1B2C3D4, 8'hD4, 1'b0, 1'b0},
    {4'b0010, 32'hA1B2C3D4, 8'hC3, 1'b0, 1'b0},
    {4'b0100, 32'hA1B2C3D4, 8'hB2, 1'b0, 1'b0},
    {4'b1000, 32'hA1B2C3D4, 8'hA1, 1'b0, 1'b0},
    {4'b0000, 32'hA1B2C3D4, 8'hFF, 1'b0, 1'b1},
    {4'b0011, 32'hA1B2C3D4, 8'h00, 1'b1, 1'b0},
    {4'b1111, 32'hFFFFFFFF, 8'h00, 1'b1, 1'b0},
    {4'b0000, 32'h00000000, 8'hFF, 1'b0, 1'b1},
    {4'b0100, 32'hFF00FFFF, 8'h00, 1'b0, 1'b0},
    {4'b1000, 32'hFFFFFFFF, 8'hFF, 1'b0, 1'b0}
  };

  tsbus_resolver #(.N_SRC(N), .WIDTH(W)) u0 (
    .src_data(src_data), .src_oe(src_oe), .bus_out(bus_out),
    .bus_conflict(bus_conflict), .bus_idle(bus_idle)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000 && !done) begin
      $display("FAIL watchdog: actual=timeout expected=finish");
      fails = fails + 1;
      checks = checks + 1;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [W-1:0] eo,
                       input logic ec, input logic ei);
    checks++;
    if (bus_out !== eo || bus_conflict !== ec || bus_idle !== ei) begin
      fails++;
      $display("FAIL %s: actual bus=%h c=%b i=%b expected bus=%h c=%b i=%b",
               req, bus_out, bus_conflict, bus_idle, eo, ec, ei);
    end
  endtask

  task automatic apply(input logic [N-1:0] oe, input logic [N*W-1:0] d);
    @(posedge clk);
    src_oe = oe;
    src_data = d;
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] model(input logic [N-1:0] oe, input logic [N*W-1:0] d);
    int n = 0;
    logic [W-1:0] v = '0;
    for (int i = 0; i < N; i++) if (oe[i]) begin n++; v = d[i*W +: W]; end
    if (n == 0) return '1;
    if (n > 1) return '0;
    return v;
  endfunction

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R3 R5: state after reset with nothing enabled
    check("R3 reset", 8'hFF, 1'b0, 1'b1);

    for (int k = 0; k < NV; k++) begin
      apply(VEC[k][VW-1 -: N], VEC[k][VW-N-1 -: N*W]);
      // R1 R2 R3 R4 R5 R7 table vector
      check($sformatf("R1/R2/R3/R4/R5/R7 vec%0d", k), VEC[k][W+1:2], VEC[k][1], VEC[k][0]);
    end

    for (int m = 0; m < (1 << N); m++) begin
      logic [N*W-1:0] d = 32'h5A3C_96E1 ^ (m * 32'h1357_2468);
      apply(m[N-1:0], d);
      // R4 R5 R8 full enable sweep
      check($sformatf("R4/R5/R8 sweep oe=%0d", m), model(m[N-1:0], d),
            $countones(m[N-1:0]) > 1, m == 0);
    end

    // R6: disabled sources change, enabled source 1 holds the bus
    apply(4'b0010, 32'h00_00_77_00);
    check("R6 base", 8'h77, 1'b0, 1'b0);
    apply(4'b0010, 32'hEE_DD_77_CC);
    check("R6 others toggled", 8'h77, 1'b0, 1'b0);
    // R6: idle bus ignores all data
    apply(4'b0000, 32'h12_34_56_78);
    check("R6 idle ignores data", 8'hFF, 1'b0, 1'b1);
    // R2: conflict with zero-free data still zero
    apply(4'b1001, 32'hFF_FF_FF_FF);
    check("R2 conflict ends", 8'h00, 1'b1, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule